// File: doc/BRIEF.md
# Proportional-Integral Loop Filter with Acquisition/Locked Bandwidth Switching

This block is the loop filter of a digital phase-locked loop. Each time the phase detector delivers a signed phase-error sample with its valid strobe, the filter updates a registered frequency-control word. That word is the sum of an integral path and a proportional path, clamped to a programmable signed frequency window. The integral path is also output on its own. It changes slowly, at a rate set by the bandwidth, so holdover logic can take it as an averaged frequency estimate.

The loop gains come from a bandwidth code. Two codes are programmable: one for pulling in and one for locked operation. With automatic switching enabled, the filter uses the acquisition code while the loop reports no phase lock and the locked code once lock is reported. With automatic switching disabled, the locked code is used at all times. The eight codes stand for a span of roughly 18 Hz to 400 Hz. A higher code is a wider bandwidth, which means smaller shifts and therefore larger gains. An optional anti-windup mode stops the integrator from pushing further while the output sits at a frequency limit. This limits overshoot during pull-in.

Top module: `pi_loop_filter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `integ_out` and `freq_out` are cleared to zero, whether or not `err_valid` is high.
- R2: On edges where `err_valid` is low, `integ_out` and `freq_out` keep their values, whatever the other inputs do.
- R3: With `auto_bw` = 1 and `locked` = 0, the gains come from `acq_bw`.
- R4: With `auto_bw` = 1 and `locked` = 1, the gains come from `lock_bw`.
- R5: With `auto_bw` = 0, the gains come from `lock_bw`, whatever the value of `locked`.
- R6: For a selected code c (0..7), the proportional shift is 7 - c and the integral shift is 10 - c. Both are arithmetic right shifts of the error, so they round toward minus infinity.
- R7: On a valid sample, the integrator becomes clamp(integ + (err >>> integral shift), freq_min, freq_max).
- R8: In the same cycle, `freq_out` becomes clamp(new integ + (err >>> proportional shift), freq_min, freq_max). It therefore never leaves the window.
- R9: With `lim_int` = 1, a valid sample leaves the integrator unchanged when `freq_out` equals `freq_max` and the increment is positive, or when `freq_out` equals `freq_min` and the increment is negative.
- R10: With `lim_int` = 1 and `freq_out` at a limit, an increment that points back into the window still updates the integrator.
- R11: With `lim_int` = 0, the integrator keeps updating while `freq_out` sits at a limit, and is bounded only by the R7 clamp.
- R12: A change of the selected bandwidth code takes effect at the next valid sample and does not reset the integrator. The integrator continues from its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_valid | input | 1 | Phase-error sample strobe |
| err_in | input | ERR_W | Signed phase error |
| locked | input | 1 | Loop reports phase lock |
| auto_bw | input | 1 | Enable automatic bandwidth switching |
| lim_int | input | 1 | Enable integrator freeze at the limits |
| acq_bw | input | CODE_W | Bandwidth code used while acquiring |
| lock_bw | input | CODE_W | Bandwidth code used while locked |
| freq_min | input | FREQ_W | Signed lower frequency limit |
| freq_max | input | FREQ_W | Signed upper frequency limit |
| freq_out | output | FREQ_W | Signed frequency-control word |
| integ_out | output | FREQ_W | Signed integral-path value |

## Verification
The bench sweeps every bandwidth code against extreme, unit and mid-range errors, in all three selection modes. A swapped code choice, a wrong shift or a logical rather than arithmetic shift would show as a mismatch on the first negative or full-scale sample. It drives the output into the upper and lower limits with a tightened window. A design that froze on any limit contact would then fail to recover on an error that points back into the window. A design that ignored the freeze mode would let the integrator climb into the clamp, and a design that never clamped the integrator would wind up without bound. It also toggles the lock indication in the middle of a stream, which catches a design that clears the integrator when the bandwidth changes.

// File: rtl/pi_lf_pkg.sv
// Shared types for the PI loop filter.
// Assumes shift amounts never exceed 15.
package pi_lf_pkg;
    localparam int SHIFT_W = 4;

    typedef struct packed {
        logic [SHIFT_W-1:0] p_shift;
        logic [SHIFT_W-1:0] i_shift;
    } gain_shift_t;
endpackage

// File: rtl/bw_gain_map.sv
// Bandwidth selection and gain lookup.
// Picks the acquisition or locked code and turns it into a pair of shifts.
// Assumes P_SHIFT_MAX and I_SHIFT_MAX are at least 2**CODE_W - 1 and below 16.
module bw_gain_map #(
    parameter int CODE_W      = 3,
    parameter int P_SHIFT_MAX = 7,
    parameter int I_SHIFT_MAX = 10
) (
    input  logic              auto_bw,
    input  logic              locked,
    input  logic [CODE_W-1:0] acq_bw,
    input  logic [CODE_W-1:0] lock_bw,
    output pi_lf_pkg::gain_shift_t gains
);
    localparam int NUM_CODES = 1 << CODE_W;

    pi_lf_pkg::gain_shift_t table_q [NUM_CODES];
    logic [CODE_W-1:0]      sel_code;

    // Build one table entry per code: a wider bandwidth gives a smaller shift.
    for (genvar c = 0; c < NUM_CODES; c++) begin : g_tab
        assign table_q[c].p_shift = pi_lf_pkg::SHIFT_W'(P_SHIFT_MAX - c);
        assign table_q[c].i_shift = pi_lf_pkg::SHIFT_W'(I_SHIFT_MAX - c);
    end

    // Choose which programmed code is active for the next sample.
    always_comb begin
        if (auto_bw && !locked) sel_code = acq_bw;
        else                    sel_code = lock_bw;
    end

    assign gains = table_q[sel_code];
endmodule

// File: rtl/pi_integrator.sv
// Integral path with range clamp and optional anti-windup freeze.
// Updates only on valid samples and exposes the next value combinationally
// so that the output stage can use it in the same cycle.
// Assumes ERR_W <= FREQ_W and freq_min <= freq_max.
module pi_integrator #(
    parameter int ERR_W  = 12,
    parameter int FREQ_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      err_valid,
    input  logic signed [ERR_W-1:0]   err_in,
    input  logic [pi_lf_pkg::SHIFT_W-1:0] i_shift,
    input  logic                      lim_int,
    input  logic signed [FREQ_W-1:0]  freq_now,
    input  logic signed [FREQ_W-1:0]  freq_min,
    input  logic signed [FREQ_W-1:0]  freq_max,
    output logic signed [FREQ_W-1:0]  integ_next,
    output logic signed [FREQ_W-1:0]  integ_q
);
    localparam int W = FREQ_W + 2;

    logic signed [W-1:0] err_w, inc_w, sum_w, lo_w, hi_w;
    logic                freeze;

    // Extend operands so the addition cannot wrap.
    always_comb begin
        err_w = {{(W-ERR_W){err_in[ERR_W-1]}}, err_in};
        lo_w  = {{2{freq_min[FREQ_W-1]}}, freq_min};
        hi_w  = {{2{freq_max[FREQ_W-1]}}, freq_max};
        inc_w = err_w >>> i_shift;
        sum_w = {{2{integ_q[FREQ_W-1]}}, integ_q} + inc_w;
    end

    // Freeze only when the update would push further past the limit in use.
    always_comb begin
        freeze = lim_int && (((freq_now == freq_max) && (inc_w > 0)) ||
                             ((freq_now == freq_min) && (inc_w < 0)));
    end

    // Next integrator value: held, or the clamped sum.
    always_comb begin
        if (freeze)            integ_next = integ_q;
        else if (sum_w > hi_w) integ_next = freq_max;
        else if (sum_w < lo_w) integ_next = freq_min;
        else                   integ_next = sum_w[FREQ_W-1:0];
    end

    // Integrator register.
    always_ff @(posedge clk) begin
        if (!rst_n)         integ_q <= '0;
        else if (err_valid) integ_q <= integ_next;
    end
endmodule

// File: rtl/pi_output_stage.sv
// Proportional path, sum and output saturation.
// Registers the frequency word on valid samples.
// Assumes ERR_W <= FREQ_W and freq_min <= freq_max.
module pi_output_stage #(
    parameter int ERR_W  = 12,
    parameter int FREQ_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      err_valid,
    input  logic signed [ERR_W-1:0]   err_in,
    input  logic [pi_lf_pkg::SHIFT_W-1:0] p_shift,
    input  logic signed [FREQ_W-1:0]  integ_next,
    input  logic signed [FREQ_W-1:0]  freq_min,
    input  logic signed [FREQ_W-1:0]  freq_max,
    output logic signed [FREQ_W-1:0]  freq_q
);
    localparam int W = FREQ_W + 2;

    logic signed [W-1:0]      err_w, prop_w, sum_w, lo_w, hi_w;
    logic signed [FREQ_W-1:0] freq_d;

    // Proportional term added to the new integral value.
    always_comb begin
        err_w  = {{(W-ERR_W){err_in[ERR_W-1]}}, err_in};
        lo_w   = {{2{freq_min[FREQ_W-1]}}, freq_min};
        hi_w   = {{2{freq_max[FREQ_W-1]}}, freq_max};
        prop_w = err_w >>> p_shift;
        sum_w  = {{2{integ_next[FREQ_W-1]}}, integ_next} + prop_w;
    end

    // Saturate the sum to the programmed window.
    always_comb begin
        if (sum_w > hi_w)      freq_d = freq_max;
        else if (sum_w < lo_w) freq_d = freq_min;
        else                   freq_d = sum_w[FREQ_W-1:0];
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n)         freq_q <= '0;
        else if (err_valid) freq_q <= freq_d;
    end
endmodule

// File: rtl/pi_loop_filter.sv
// PI loop filter top: gain selection, integral path and output stage.
// One update per valid sample; both outputs are registered.
// Assumes freq_min <= freq_max and that the limits hold steady between samples.
module pi_loop_filter #(
    parameter int ERR_W       = 12,
    parameter int FREQ_W      = 16,
    parameter int CODE_W      = 3,
    parameter int P_SHIFT_MAX = 7,
    parameter int I_SHIFT_MAX = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     err_valid,
    input  logic signed [ERR_W-1:0]  err_in,
    input  logic                     locked,
    input  logic                     auto_bw,
    input  logic                     lim_int,
    input  logic [CODE_W-1:0]        acq_bw,
    input  logic [CODE_W-1:0]        lock_bw,
    input  logic signed [FREQ_W-1:0] freq_min,
    input  logic signed [FREQ_W-1:0] freq_max,
    output logic signed [FREQ_W-1:0] freq_out,
    output logic signed [FREQ_W-1:0] integ_out
);
    pi_lf_pkg::gain_shift_t   gains;
    logic signed [FREQ_W-1:0] integ_next;

    bw_gain_map #(
        .CODE_W(CODE_W), .P_SHIFT_MAX(P_SHIFT_MAX), .I_SHIFT_MAX(I_SHIFT_MAX)
    ) u_map (
        .auto_bw(auto_bw), .locked(locked),
        .acq_bw(acq_bw), .lock_bw(lock_bw), .gains(gains)
    );

    pi_integrator #(.ERR_W(ERR_W), .FREQ_W(FREQ_W)) u_int (
        .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_in(err_in),
        .i_shift(gains.i_shift), .lim_int(lim_int), .freq_now(freq_out),
        .freq_min(freq_min), .freq_max(freq_max),
        .integ_next(integ_next), .integ_q(integ_out)
    );

    pi_output_stage #(.ERR_W(ERR_W), .FREQ_W(FREQ_W)) u_out (
        .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_in(err_in),
        .p_shift(gains.p_shift), .integ_next(integ_next),
        .freq_min(freq_min), .freq_max(freq_max), .freq_q(freq_out)
    );
endmodule

// File: rtl/pi_loop_filter_chk.sv
// Port-level assertions for pi_loop_filter, attached with bind.
module pi_loop_filter_chk #(
    parameter int ERR_W  = 12,
    parameter int FREQ_W = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     err_valid,
    input logic signed [ERR_W-1:0]  err_in,
    input logic                     lim_int,
    input logic signed [FREQ_W-1:0] freq_min,
    input logic signed [FREQ_W-1:0] freq_max,
    input logic signed [FREQ_W-1:0] freq_out,
    input logic signed [FREQ_W-1:0] integ_out
);
    // R1: reset clears both outputs
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (freq_out == '0 && integ_out == '0));

    // R2: no sample, no change
    p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !err_valid |=> ($stable(freq_out) && $stable(integ_out)));

    // R8: output stays inside the window after an update
    p_out_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |=> (freq_out >= $past(freq_min) && freq_out <= $past(freq_max)));

    // R7: integrator stays inside the window after an update
    p_integ_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && !lim_int) |=>
            (integ_out >= $past(freq_min) && integ_out <= $past(freq_max)));

    // R9: frozen at the upper limit for a positive error
    p_freeze_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && lim_int && freq_out == freq_max && err_in > 0) |=> $stable(integ_out));

    // R9: frozen at the lower limit for a negative error
    p_freeze_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && lim_int && freq_out == freq_min && err_in < 0) |=> $stable(integ_out));
endmodule

bind pi_loop_filter pi_loop_filter_chk #(.ERR_W(ERR_W), .FREQ_W(FREQ_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_in(err_in),
    .lim_int(lim_int), .freq_min(freq_min), .freq_max(freq_max),
    .freq_out(freq_out), .integ_out(integ_out)
);

// File: tb/pi_loop_filter_test.sv
// Self-checking bench for pi_loop_filter, with an arithmetic reference model.
module pi_loop_filter_test;
    localparam int ERR_W  = 12;
    localparam int FREQ_W = 16;
    localparam int CODE_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic err_valid = 1'b0;
    logic signed [ERR_W-1:0] err_in = '0;
    logic locked = 1'b0, auto_bw = 1'b0, lim_int = 1'b0;
    logic [CODE_W-1:0] acq_bw = '0, lock_bw = '0;
    logic signed [FREQ_W-1:0] freq_min = -16'sd2000, freq_max = 16'sd2000;
    logic signed [FREQ_W-1:0] freq_out, integ_out;

    int checks = 0;
    int fails  = 0;
    longint m_integ = 0, m_freq = 0;

    pi_loop_filter uut (
        .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_in(err_in),
        .locked(locked), .auto_bw(auto_bw), .lim_int(lim_int),
        .acq_bw(acq_bw), .lock_bw(lock_bw), .freq_min(freq_min), .freq_max(freq_max),
        .freq_out(freq_out), .integ_out(integ_out)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic longint clampv(input longint v);
        longint lo = longint'(freq_min);
        longint hi = longint'(freq_max);
        return (v > hi) ? hi : (v < lo) ? lo : v;
    endfunction

    // Apply one valid sample, advance the model, compare both outputs.
    task automatic sample(input longint e, input string tag);
        longint code, inc, prop, sum_i;
        bit     frz;
        @(negedge clk);
        err_in    = ERR_W'(e);
        err_valid = 1'b1;
        code  = (auto_bw && !locked) ? longint'(acq_bw) : longint'(lock_bw);
        inc   = e >>> (10 - code);
        prop  = e >>> (7 - code);
        frz   = lim_int && ((m_freq == longint'(freq_max) && inc > 0) ||
                            (m_freq == longint'(freq_min) && inc < 0));
        sum_i = frz ? m_integ : clampv(m_integ + inc);
        m_integ = sum_i;
        m_freq  = clampv(m_integ + prop);
        @(negedge clk);
        err_valid = 1'b0;
        check(tag, "integ_out", longint'(integ_out), m_integ);
        check(tag, "freq_out",  longint'(freq_out),  m_freq);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        err_valid = 1'b1;
        err_in = 12'sd1000;
        @(negedge clk);
        @(negedge clk);
        err_valid = 1'b0;
        rst_n = 1'b1;
        m_integ = 0;
        m_freq  = 0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        longint errs[8] = '{-2048, -1000, -1, 0, 1, 5, 777, 2047};
        longint hold_f, hold_i;

        // R1: reset clears outputs even with a valid sample present
        do_reset();
        check("R1", "integ_out", longint'(integ_out), 0);
        check("R1", "freq_out",  longint'(freq_out),  0);

        // R5, R6, R7, R8: fixed selection, every code, both lock states
        auto_bw = 1'b0;
        for (int c = 0; c < 8; c++) begin
            for (int l = 0; l < 2; l++) begin
                lock_bw = CODE_W'(c);
                acq_bw  = CODE_W'(7 - c);
                locked  = l[0];
                foreach (errs[i]) sample(errs[i], "R5_R6_R7_R8");
            end
        end

        // R3, R4: automatic selection in both lock states
        do_reset();
        auto_bw = 1'b1;
        for (int c = 0; c < 8; c++) begin
            acq_bw  = CODE_W'(c);
            lock_bw = CODE_W'(7 - c);
            locked = 1'b0;
            foreach (errs[i]) sample(errs[i], "R3");
            locked = 1'b1;
            foreach (errs[i]) sample(errs[i], "R4");
        end

        // R2: idle cycles with changing inputs leave outputs alone
        sample(300, "R2");
        hold_f = longint'(freq_out);
        hold_i = longint'(integ_out);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            err_in = ERR_W'(k * 311 - 900);
            locked = ~locked;
            lock_bw = CODE_W'(k);
        end
        @(negedge clk);
        check("R2", "freq_out idle",  longint'(freq_out),  hold_f);
        check("R2", "integ_out idle", longint'(integ_out), hold_i);

        // R12: bandwidth switch mid-stream keeps the integrator
        do_reset();
        auto_bw = 1'b1; acq_bw = 3'd7; lock_bw = 3'd0; locked = 1'b0;
        sample(2047, "R12");
        sample(2047, "R12");
        locked = 1'b1;
        sample(2047, "R12");
        check("R12", "integ continues", longint'(integ_out), 255 + 255 + 1);
        locked = 1'b0;
        sample(-1000, "R12");

        // R9, R10: freeze at the upper limit, recover toward the window
        freq_min = -16'sd300; freq_max = 16'sd300;
        do_reset();
        auto_bw = 1'b0; lock_bw = 3'd7; lim_int = 1'b1;
        sample(2047, "R9");
        sample(2047, "R9");
        check("R9", "integ frozen high", longint'(integ_out), 255);
        sample(-800, "R10");
        check("R10", "integ moved down", longint'(integ_out), 155);
        // R9, R10: freeze at the lower limit, recover upward
        for (int k = 0; k < 4; k++) sample(-2048, "R9");
        sample(-2048, "R9");
        sample(900, "R10");

        // R11: no freeze when limiting is off
        do_reset();
        lim_int = 1'b0;
        sample(2047, "R11");
        sample(2047, "R11");
        check("R11", "integ clamps at max", longint'(integ_out), 300);
        sample(-2048, "R11");
        sample(-2048, "R11");
        sample(-2048, "R11");
        check("R11", "integ clamps at min", longint'(integ_out), -300);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule